// File: doc/BRIEF.md
# SPI Diagnostic Slave Port

This block is the serial slave port of a multichannel power-switch controller. A host lowers an active-low select and clocks a 16-bit control word in on the data-in pin, most significant bit first. At the same time the port returns a 16-bit diagnosis word on the data-out pin. The received word reaches the channel outputs only when select is released, and only if the frame held exactly 16 accepted bits.

A fast system clock oversamples all serial pins through two-flop synchronizers, and every edge is found in that clock domain. The port enforces minimum timing on the serial clock. A rising edge is accepted only after a lead time counted from select falling, and only if the preceding low phase was long enough. A falling edge is accepted only if its high phase was long enough and the rising edge before it was accepted. Edges that break these limits are dropped. A separate active-low clear pin, also synchronized, empties the shift state and turns every channel off.

Top module: `spi_diag_slave`

## Requirements
- R1: `sdo_oe` is high exactly while the synchronized select is low, lagging `cs_n` by two clock edges. `sdo` is 0 whenever `sdo_oe` is low.
- R2: On each accepted falling `sclk` edge, `sdi` is shifted in MSB first. If exactly 16 falling edges were accepted when `cs_n` rises, `ctrl_word` takes the word three edges later, with the first bit received in bit 15.
- R3: A frame with any other count of accepted falling edges (15, 17, ...) leaves `ctrl_word` unchanged.
- R4: `diag_word` is captured when select falls. Bit 15 appears on `sdo` after the first accepted rising edge, and each later accepted rising edge presents the next lower bit. `sdo` is 0 before the first accepted rise and after the sixteenth.
- R5: A rising edge is dropped when fewer than `LEAD_CYC` cycles have passed since select fell. Exactly `LEAD_CYC` cycles is accepted.
- R6: A rising edge is dropped if the low phase before it was shorter than `MIN_LO_CYC`. A falling edge is dropped if the high phase before it was shorter than `MIN_HI_CYC`, or if its rising edge was dropped.
- R7: `sclk` activity while `cs_n` is high changes neither `ctrl_word` nor the bit count of the next frame.
- R8: While `spi_rst_n` is low, `ctrl_word` is 0 (all channels off), `sdo` stays 0, and a complete frame has no effect.
- R9: Synchronous `rst` drives `ctrl_word`, `sdo_oe` and `sdo` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_rst_n | input | 1 | Asynchronous-pin active-low clear of shift state and channel word |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| diag_word | input | WORD_W | Diagnosis word returned in the next frame |
| sdo | output | 1 | Serial diagnosis data to the host |
| sdo_oe | output | 1 | Output enable for `sdo`; low means the pin floats |
| ctrl_word | output | WORD_W | Channel control word; 1 turns a channel on |

## Verification
A pin driven just before clock edge k is seen by the port's edge logic after edge k+1. So `sdo_oe` moves after edge k+1, while `ctrl_word` and the registered `sdo` bit move after edge k+2. The bench reference model pushes each predicted value into a delay line of matching length: two stages for the enable and three for the word and the data bit. It compares every output at the falling clock edge of every cycle. Timing limits are stated in whole cycles, so the bench drives lead, high and low phases as exact cycle counts and predicts acceptance at, just below and above each limit.

// File: rtl/spi_diag_pkg.sv
`timescale 1ns/1ps
package spi_diag_pkg;

    // Index of each pin inside the synchronizer bank
    localparam int PIN_N   = 4;
    localparam int PIN_CS  = 0;
    localparam int PIN_SCK = 1;
    localparam int PIN_SDI = 2;
    localparam int PIN_CLR = 3;

    // Idle level of each pin after reset: select high, clear inactive high
    localparam logic [PIN_N-1:0] PIN_IDLE = 4'b1001;

    // Events passed from the timing qualifier to the shift core
    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic rise_ok;
        logic fall_ok;
    } spi_evt_t;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_bits(int v);
        return (v < 1) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
    parameter int          N       = 4,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o
);

    for (genvar g = 0; g < N; g++) begin : g_sync
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= RST_VAL[g];
                stab_q <= RST_VAL[g];
            end else begin
                meta_q <= pin_i[g];
                stab_q <= meta_q;
            end
        end
        assign lvl_o[g] = stab_q;
    end

endmodule

// File: rtl/spi_edge_qual.sv
`timescale 1ns/1ps
module spi_edge_qual
    import spi_diag_pkg::*;
#(
    parameter int LEAD_CYC   = 25,
    parameter int MIN_HI_CYC = 3,
    parameter int MIN_LO_CYC = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_lvl,
    input  logic     sck_lvl,
    output spi_evt_t evt_o
);

    localparam int LW   = cnt_bits(LEAD_CYC);
    localparam int WMAX = imax(imax(MIN_HI_CYC, MIN_LO_CYC), 1);
    localparam int WW   = cnt_bits(WMAX);
    localparam logic [LW-1:0] LEAD_V = LW'(LEAD_CYC);
    localparam logic [WW-1:0] WMAX_V = WW'(WMAX);
    localparam logic [WW-1:0] HI_V   = WW'(MIN_HI_CYC);
    localparam logic [WW-1:0] LO_V   = WW'(MIN_LO_CYC);

    logic          cs_prev, sck_prev;
    logic [LW-1:0] lead_cnt;
    logic [WW-1:0] wid_cnt;
    logic          armed;
    logic          sck_rise, sck_fall, rise_ok, fall_ok;

    assign sck_rise = sck_lvl & ~sck_prev;
    assign sck_fall = ~sck_lvl & sck_prev;
    assign rise_ok  = sck_rise & ~cs_lvl & (lead_cnt >= LEAD_V) & (wid_cnt >= LO_V);
    assign fall_ok  = sck_fall & ~cs_lvl & armed & (wid_cnt >= HI_V);

    always_comb begin
        evt_o.cs_fall = cs_prev & ~cs_lvl;
        evt_o.cs_rise = ~cs_prev & cs_lvl;
        evt_o.rise_ok = rise_ok;
        evt_o.fall_ok = fall_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
            lead_cnt <= '0;
            wid_cnt  <= WMAX_V;
            armed    <= 1'b0;
        end else begin
            cs_prev  <= cs_lvl;
            sck_prev <= sck_lvl;
            // cycles elapsed since select went low, saturating at the limit
            if (cs_lvl)
                lead_cnt <= '0;
            else if (lead_cnt != LEAD_V)
                lead_cnt <= lead_cnt + 1'b1;
            // length of the current serial clock phase, saturating
            if (sck_lvl != sck_prev)
                wid_cnt <= WW'(1);
            else if (wid_cnt != WMAX_V)
                wid_cnt <= wid_cnt + 1'b1;
            // a falling edge only counts when its rising edge counted
            if (cs_lvl)
                armed <= 1'b0;
            else if (rise_ok)
                armed <= 1'b1;
            else if (sck_fall)
                armed <= 1'b0;
        end
    end

    if (LEAD_CYC >= 2) begin : g_lead_chk
        assert_lead_R5: assert property (@(posedge clk) disable iff (rst)
            evt_o.cs_fall |=> !rise_ok);
    end

    if (MIN_HI_CYC >= 2) begin : g_high_chk
        assert_high_width_R6: assert property (@(posedge clk) disable iff (rst)
            rise_ok |=> !fall_ok);
    end

endmodule

// File: rtl/spi_shift_core.sv
`timescale 1ns/1ps
module spi_shift_core
    import spi_diag_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sdi_lvl,
    input  spi_evt_t          evt_i,
    input  logic [WORD_W-1:0] diag_i,
    output logic [WORD_W-1:0] ctrl_o,
    output logic              sdo_o
);

    localparam int CNT_MAX = WORD_W + 1;
    localparam int CW      = cnt_bits(CNT_MAX);
    localparam logic [CW-1:0] FULL_V = CW'(WORD_W);
    localparam logic [CW-1:0] SAT_V  = CW'(CNT_MAX);

    logic [WORD_W-1:0] in_sr, out_sr, ctrl_q;
    logic [CW-1:0]     bit_cnt;
    logic              sdo_q;
    logic              in_frame;

    always_ff @(posedge clk) begin
        if (rst)
            in_frame <= 1'b0;
        else if (evt_i.cs_fall)
            in_frame <= 1'b1;
        else if (evt_i.cs_rise)
            in_frame <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            in_sr   <= '0;
            out_sr  <= '0;
            ctrl_q  <= '0;
            bit_cnt <= '0;
            sdo_q   <= 1'b0;
        end else if (evt_i.cs_fall) begin
            out_sr  <= diag_i;
            bit_cnt <= '0;
            sdo_q   <= 1'b0;
        end else if (evt_i.cs_rise) begin
            if (bit_cnt == FULL_V)
                ctrl_q <= in_sr;
            bit_cnt <= '0;
            sdo_q   <= 1'b0;
        end else if (in_frame) begin
            if (evt_i.rise_ok) begin
                sdo_q  <= out_sr[WORD_W-1];
                out_sr <= {out_sr[WORD_W-2:0], 1'b0};
            end
            if (evt_i.fall_ok) begin
                in_sr <= {in_sr[WORD_W-2:0], sdi_lvl};
                if (bit_cnt != SAT_V)
                    bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    assign ctrl_o = ctrl_q;
    assign sdo_o  = sdo_q;

    assert_idle_edges_R7: assert property (@(posedge clk) disable iff (rst)
        (evt_i.rise_ok || evt_i.fall_ok) |-> in_frame);

    assert_short_frame_R3: assert property (@(posedge clk) disable iff (rst)
        (evt_i.cs_rise && !clear && bit_cnt != FULL_V) |=> $stable(ctrl_q));

    assert_clear_off_R8: assert property (@(posedge clk) disable iff (rst)
        clear |=> (ctrl_q == '0 && !sdo_q));

    assert_reset_off_R9: assert property (@(posedge clk)
        rst |=> (ctrl_q == '0 && !sdo_q));

endmodule

// File: rtl/spi_diag_slave.sv
`timescale 1ns/1ps
module spi_diag_slave
    import spi_diag_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int LEAD_CYC   = 25,
    parameter int MIN_HI_CYC = 3,
    parameter int MIN_LO_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic [WORD_W-1:0] diag_word,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [WORD_W-1:0] ctrl_word
);

    logic [PIN_N-1:0] pin_raw, pin_lvl;
    spi_evt_t         evt;
    logic             sdo_bit;

    always_comb begin
        pin_raw          = '0;
        pin_raw[PIN_CS]  = cs_n;
        pin_raw[PIN_SCK] = sclk;
        pin_raw[PIN_SDI] = sdi;
        pin_raw[PIN_CLR] = spi_rst_n;
    end

    spi_pin_sync #(
        .N      (PIN_N),
        .RST_VAL(PIN_IDLE)
    ) i_sync (
        .clk  (clk),
        .rst  (rst),
        .pin_i(pin_raw),
        .lvl_o(pin_lvl)
    );

    spi_edge_qual #(
        .LEAD_CYC  (LEAD_CYC),
        .MIN_HI_CYC(MIN_HI_CYC),
        .MIN_LO_CYC(MIN_LO_CYC)
    ) i_qual (
        .clk    (clk),
        .rst    (rst),
        .cs_lvl (pin_lvl[PIN_CS]),
        .sck_lvl(pin_lvl[PIN_SCK]),
        .evt_o  (evt)
    );

    spi_shift_core #(
        .WORD_W(WORD_W)
    ) i_core (
        .clk    (clk),
        .rst    (rst),
        .clear  (~pin_lvl[PIN_CLR]),
        .sdi_lvl(pin_lvl[PIN_SDI]),
        .evt_i  (evt),
        .diag_i (diag_word),
        .ctrl_o (ctrl_word),
        .sdo_o  (sdo_bit)
    );

    assign sdo_oe = ~pin_lvl[PIN_CS];
    assign sdo    = sdo_oe & sdo_bit;

endmodule

// File: tb/test_spi_diag_slave.sv
`timescale 1ns/1ps
module test_spi_diag_slave;

    localparam int LEAD = 25;
    localparam int MHI  = 3;
    localparam int MLO  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_rst_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic [15:0] diag_word = '0;
    logic        sdo, sdo_oe;
    logic [15:0] ctrl_word;

    always #4 clk = ~clk;

    spi_diag_slave #(
        .WORD_W(16), .LEAD_CYC(LEAD), .MIN_HI_CYC(MHI), .MIN_LO_CYC(MLO)
    ) i_spi_diag_slave (
        .clk(clk), .rst(rst), .spi_rst_n(spi_rst_n), .cs_n(cs_n), .sclk(sclk),
        .sdi(sdi), .diag_word(diag_word), .sdo(sdo), .sdo_oe(sdo_oe),
        .ctrl_word(ctrl_word)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    bit    clr_on = 1'b0;
    string cur_req = "R9";

    // reference model: predicted next values and delay lines
    logic [15:0] m_ctrl = '0;
    logic [15:0] exp_ctrl_nx = '0;
    logic        exp_oe_nx = 1'b0;
    logic        exp_sdo_nx = 1'b0;
    logic [15:0] pc1, pc2, pc3;
    logic        po1, po2, ps1, ps2, ps3;

    always @(posedge clk) begin
        if (rst) begin
            pc1 <= '0; pc2 <= '0; pc3 <= '0;
            po1 <= 1'b0; po2 <= 1'b0;
            ps1 <= 1'b0; ps2 <= 1'b0; ps3 <= 1'b0;
        end else begin
            pc1 <= exp_ctrl_nx; pc2 <= pc1; pc3 <= pc2;
            po1 <= exp_oe_nx;   po2 <= po1;
            ps1 <= exp_sdo_nx;  ps2 <= ps1; ps3 <= ps2;
        end
    end

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(cur_req, ctrl_word, pc3);
            check("R1", {15'b0, sdo_oe}, {15'b0, po2});
            check("R4", {15'b0, sdo}, {15'b0, po2 & ps3});
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // one select window; acceptance of every edge predicted from the limits
    task automatic frame(logic [15:0] data, int nbits, int lead, int hi, int lo);
        int          elapsed;
        int          nr;
        int          nf;
        bit          r_ok;
        bit          f_ok;
        logic [15:0] got;
        cs_n = 1'b0; exp_oe_nx = 1'b1;
        elapsed = lead; nr = 0; nf = 0; got = '0;
        cycles(lead);
        for (int i = 0; i < nbits; i++) begin
            r_ok = (elapsed >= LEAD) && (i == 0 || lo >= MLO);
            sclk = 1'b1; sdi = data[15 - (i % 16)];
            if (r_ok && !clr_on)
                exp_sdo_nx = (nr < 16) ? diag_word[15 - nr] : 1'b0;
            if (r_ok) nr++;
            cycles(hi); elapsed += hi;
            sclk = 1'b0;
            f_ok = r_ok && (hi >= MHI);
            if (f_ok) begin got = {got[14:0], sdi}; nf++; end
            cycles(lo); elapsed += lo;
        end
        cs_n = 1'b1; exp_oe_nx = 1'b0; exp_sdo_nx = 1'b0;
        if (nf == 16 && !clr_on) m_ctrl = got;
        exp_ctrl_nx = m_ctrl;
        cycles(6);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #1200000;
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        cycles(5);
        rst = 1'b0;
        cycles(1);
        check("R9", ctrl_word, 16'h0000);
        check("R9", {15'b0, sdo_oe}, 16'h0000);
        check("R9", {15'b0, sdo}, 16'h0000);

        // R2 / R4: plain frames
        cur_req = "R2";
        diag_word = 16'h9F21; cycles(3);
        frame(16'hA5C3, 16, 26, 4, 4);
        check("R2", ctrl_word, 16'hA5C3);
        cur_req = "R4";
        diag_word = 16'h8001; cycles(3);
        frame(16'h0F0F, 16, 30, 5, 3);
        check("R4", ctrl_word, 16'h0F0F);

        // R5: lead time exactly at the limit, then one cycle short
        cur_req = "R5";
        diag_word = 16'h3C5A; cycles(3);
        frame(16'h1234, 16, LEAD, MHI, MLO);
        check("R5", ctrl_word, 16'h1234);
        frame(16'hFFFF, 16, LEAD - 1, 4, 4);
        check("R5", ctrl_word, 16'h1234);

        // R3: wrong bit counts
        cur_req = "R3";
        frame(16'hABCD, 15, 26, 4, 4);
        check("R3", ctrl_word, 16'h1234);
        frame(16'hABCD, 17, 26, 4, 4);
        check("R3", ctrl_word, 16'h1234);

        // R6: short high phase, then short low phase
        cur_req = "R6";
        frame(16'h6666, 16, 26, MHI - 1, 4);
        check("R6", ctrl_word, 16'h1234);
        frame(16'h9999, 16, 26, 4, MLO - 1);
        check("R6", ctrl_word, 16'h1234);

        // R7: clock activity while deselected
        cur_req = "R7";
        for (int k = 0; k < 10; k++) begin
            sclk = 1'b1; sdi = k[0]; cycles(4);
            sclk = 1'b0; cycles(4);
        end
        check("R7", ctrl_word, 16'h1234);
        check("R7", {15'b0, sdo_oe}, 16'h0000);
        diag_word = 16'hE00F; cycles(3);
        frame(16'h5AA5, 16, 26, 4, 4);
        check("R7", ctrl_word, 16'h5AA5);

        // R8: clear pin forces channels off and blocks frames
        cur_req = "R8";
        spi_rst_n = 1'b0; clr_on = 1'b1; m_ctrl = '0; exp_ctrl_nx = '0;
        cycles(5);
        check("R8", ctrl_word, 16'h0000);
        frame(16'h7777, 16, 26, 4, 4);
        check("R8", ctrl_word, 16'h0000);
        spi_rst_n = 1'b1; clr_on = 1'b0;
        cycles(4);
        frame(16'hC0DE, 16, 26, 4, 4);
        check("R8", ctrl_word, 16'hC0DE);

        // R9: reset in mid run
        cur_req = "R9";
        rst = 1'b1; m_ctrl = '0; exp_ctrl_nx = '0;
        cycles(3);
        rst = 1'b0;
        cycles(1);
        check("R9", ctrl_word, 16'h0000);
        check("R9", {15'b0, sdo_oe}, 16'h0000);
        cycles(4);
        finish_run();
    end

endmodule